// File: doc/BRIEF.md
# CAN Error Flag Signaling Unit

This unit lives inside a CAN protocol controller and produces the error frame after another part of the controller has reported a protocol error. It moves forward by exactly one bit time on each bit-time strobe. On each strobe it samples the bus bit, where 0 means dominant. It also decides on that strobe which bit the node drives onto the bus for the next bit time.

When an error is reported, the unit looks at the transmit and receive error counters. If neither counter is above 127, it drives a dominant flag that every node on the bus will notice. If either counter is above 127, it drives a recessive flag instead, which leaves other traffic undisturbed. The recessive flag finishes only when the bus has shown six equal bits in a row, so dominant bits from other nodes can stretch it. After either flag the unit sends the error delimiter. A node in the passive state must then also observe a quiet bus before it is allowed back into traffic. A done pulse marks the moment the node may rejoin.

Top module: `can_errflag_unit`

Bit times are numbered as follows. The strobe at which an error pulse is accepted, or the first strobe after it, is strobe 1. The bus sample taken at strobe n belongs to the bit time that ended at that strobe. The value on `tx_bit` after strobe n is the bit driven up to strobe n+1.

## Requirements
- R1: After reset, `tx_bit` is 1 (recessive), and `busy`, `rejoin_ok` and `err_passive` are 0 while both counters are 0.
- R2: One clock after the counters change, `err_passive` shows whether either counter is strictly greater than 127. A value of 127 keeps the node active, and 128 makes it passive.
- R3: The flag type is fixed from the counter values in the clock where the error pulse is accepted. Later changes to the counters have no effect until the frame ends.
- R4: An active flag drives `tx_bit` to 0 after strobes 1 to 6 and to 1 after strobe 7, whatever the bus shows. With no other activity on the bus, `rejoin_ok` rises at strobe 15.
- R5: A passive flag never drives 0. It ends at the strobe where six consecutive samples of equal value have been counted, beginning with the sample at strobe 2. A change in value starts the count again at 1. On a quiet bus the flag ends at strobe 7.
- R6: After the flag, the delimiter ends when 8 consecutive recessive samples have been seen. Any dominant sample restarts the count from zero.
- R7: In passive mode, after the delimiter the unit waits for 6 more consecutive recessive samples before it signals done. A dominant sample restarts this wait. On a quiet bus, `rejoin_ok` rises at strobe 21.
- R8: `rejoin_ok` is 1 for exactly one bit time: from the completion strobe until the next strobe. `busy` is 0 from the completion strobe onward.
- R9: An error pulse while `busy` is 1 is ignored, and this includes the clock of the completion strobe. A pulse in the clock just after completion is accepted.
- R10: `tx_bit` changes only in a clock where `bit_stb` is high. It is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-clock strobe at each bit-time boundary |
| rx_bit | input | 1 | Sampled bus bit, 0 = dominant |
| err_det | input | 1 | Error-detected pulse |
| tx_err_cnt | input | CNT_W | Transmit error counter value |
| rx_err_cnt | input | CNT_W | Receive error counter value |
| tx_bit | output | 1 | Bit driven onto the bus |
| busy | output | 1 | Error frame in progress |
| err_passive | output | 1 | Node is error passive |
| rejoin_ok | output | 1 | One-bit-time pulse: node may rejoin traffic |

## Verification
Two events can land in the same clock: the strobe that completes a frame and a new error pulse. In that clock the unit is still busy, so the pulse must be lost. The bench drives both signals high together in the completion clock, then checks that `rejoin_ok` rises while `busy` stays low. It then raises an error pulse together with a strobe while the unit is idle and `rejoin_ok` is still high. It checks that this second pulse is taken, that the flag begins only at the next strobe, and that the new frame finishes on the normal strobe count.

// File: rtl/can_ef_pkg.sv
package can_ef_pkg;

  typedef enum logic [2:0] {
    EF_IDLE,
    EF_ARM,
    EF_ACTIVE,
    EF_PASSIVE,
    EF_DELIM,
    EF_REJOIN
  } ef_state_t;

endpackage

// File: rtl/ef_mode_eval.sv
module ef_mode_eval #(
  parameter int CNT_W = 9,
  parameter int LIMIT = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  output logic             passive_now,
  output logic             err_passive
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  assign passive_now = (tec > LIM) || (rec > LIM);

  always_ff @(posedge clk) begin
    if (rst) err_passive <= 1'b0;
    else     err_passive <= passive_now;
  end
endmodule

// File: rtl/ef_run_counter.sv
// Counts a run of bus samples. EQUAL_MODE=1 counts samples that equal the
// previous one; EQUAL_MODE=0 counts consecutive ones (recessive samples).
module ef_run_counter #(
  parameter int W          = 4,
  parameter bit EQUAL_MODE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         rx,
  output logic [W-1:0] run_next
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] run;
  logic [W-1:0] run_inc;

  assign run_inc = (run == MAXV) ? MAXV : run + ONE;

  generate
    if (EQUAL_MODE) begin : g_equal
      logic prev;
      assign run_next = ((run == '0) || (rx != prev)) ? ONE : run_inc;
      always_ff @(posedge clk) begin
        if (rst)       prev <= 1'b1;
        else if (step) prev <= rx;
      end
    end else begin : g_recessive
      assign run_next = rx ? run_inc : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) run <= '0;
    else if (step)  run <= run_next;
  end
endmodule

// File: rtl/can_errflag_unit.sv
module can_errflag_unit #(
  parameter int CNT_W         = 9,
  parameter int PASSIVE_LIMIT = 127,
  parameter int FLAG_BITS     = 6,
  parameter int DELIM_BITS    = 8,
  parameter int REJOIN_BITS   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             err_det,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  output logic             tx_bit,
  output logic             busy,
  output logic             err_passive,
  output logic             rejoin_ok
);
  import can_ef_pkg::*;

  localparam int MAX_A  = (FLAG_BITS > DELIM_BITS) ? FLAG_BITS : DELIM_BITS;
  localparam int MAXLEN = (MAX_A > REJOIN_BITS) ? MAX_A : REJOIN_BITS;
  localparam int RUN_W  = $clog2(MAXLEN + 1);
  localparam logic [RUN_W-1:0] FLAG_N   = RUN_W'(FLAG_BITS);
  localparam logic [RUN_W-1:0] DELIM_N  = RUN_W'(DELIM_BITS);
  localparam logic [RUN_W-1:0] REJOIN_N = RUN_W'(REJOIN_BITS);

  ef_state_t        state_q, state_d;
  logic             mode_q;
  logic             passive_now;
  logic             advance;
  logic             finish;
  logic [RUN_W-1:0] flag_next, eq_next, rec_next;

  ef_mode_eval #(.CNT_W(CNT_W), .LIMIT(PASSIVE_LIMIT)) u_mode (
    .clk(clk), .rst(rst), .tec(tx_err_cnt), .rec(rx_err_cnt),
    .passive_now(passive_now), .err_passive(err_passive)
  );

  // active flag length: counts bit times, input tied recessive
  ef_run_counter #(.W(RUN_W), .EQUAL_MODE(1'b0)) u_flag_len (
    .clk(clk), .rst(rst), .clr(advance),
    .step(bit_stb && (state_q == EF_ACTIVE)),
    .rx(1'b1), .run_next(flag_next)
  );

  // passive flag: equal-polarity run on the bus
  ef_run_counter #(.W(RUN_W), .EQUAL_MODE(1'b1)) u_eq_run (
    .clk(clk), .rst(rst), .clr(advance),
    .step(bit_stb && (state_q == EF_PASSIVE)),
    .rx(rx_bit), .run_next(eq_next)
  );

  // delimiter and rejoin wait: recessive run on the bus
  ef_run_counter #(.W(RUN_W), .EQUAL_MODE(1'b0)) u_rec_run (
    .clk(clk), .rst(rst), .clr(advance),
    .step(bit_stb && ((state_q == EF_DELIM) || (state_q == EF_REJOIN))),
    .rx(rx_bit), .run_next(rec_next)
  );

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    unique case (state_q)
      EF_IDLE:    if (err_det) state_d = EF_ARM;
      EF_ARM:     if (bit_stb) state_d = mode_q ? EF_PASSIVE : EF_ACTIVE;
      EF_ACTIVE:  if (bit_stb && (flag_next == FLAG_N)) state_d = EF_DELIM;
      EF_PASSIVE: if (bit_stb && (eq_next == FLAG_N)) state_d = EF_DELIM;
      EF_DELIM: begin
        if (bit_stb && (rec_next == DELIM_N)) begin
          if (mode_q) begin
            state_d = EF_REJOIN;
          end else begin
            state_d = EF_IDLE;
            finish  = 1'b1;
          end
        end
      end
      EF_REJOIN: begin
        if (bit_stb && (rec_next == REJOIN_N)) begin
          state_d = EF_IDLE;
          finish  = 1'b1;
        end
      end
      default: state_d = EF_IDLE;
    endcase
  end

  assign advance = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= EF_IDLE;
      mode_q    <= 1'b0;
      tx_bit    <= 1'b1;
      busy      <= 1'b0;
      rejoin_ok <= 1'b0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d != EF_IDLE);
      tx_bit  <= (state_d != EF_ACTIVE);
      if ((state_q == EF_IDLE) && err_det) mode_q <= passive_now;
      if (finish)       rejoin_ok <= 1'b1;
      else if (bit_stb) rejoin_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/can_errflag_checker.sv
module can_errflag_checker (
  input logic clk,
  input logic rst,
  input logic bit_stb,
  input logic err_det,
  input logic tx_bit,
  input logic busy,
  input logic done,
  input logic mode_q
);
  p_tx_on_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(tx_bit));

  p_idle_recessive_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_bit);

  p_passive_recessive_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q) |-> tx_bit);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (done && bit_stb) |=> !done);

  p_done_after_frame_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_stb) |=> busy);

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && err_det) |=> busy);
endmodule

bind can_errflag_unit can_errflag_checker u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .err_det(err_det),
  .tx_bit(tx_bit), .busy(busy), .done(rejoin_ok), .mode_q(mode_q)
);

// File: tb/can_errflag_unit_test.sv
`timescale 1ns/1ps
module can_errflag_unit_test;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_stb = 1'b0;
  logic          rx_bit = 1'b1;
  logic          err_det = 1'b0;
  logic [CW-1:0] tec = '0;
  logic [CW-1:0] rec = '0;
  logic          tx_bit, busy, err_passive, rejoin_ok;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  can_errflag_unit #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .err_det(err_det), .tx_err_cnt(tec), .rx_err_cnt(rec),
    .tx_bit(tx_bit), .busy(busy), .err_passive(err_passive),
    .rejoin_ok(rejoin_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic rx);
    @(negedge clk);
    rx_bit  = rx;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk);
    err_det = 1'b1;
    @(negedge clk);
    err_det = 1'b0;
  endtask

  // one error frame; dom[n] forces the bus dominant for bit time n
  task automatic run_frame(input string tag, input logic [63:0] dom,
                           input int exp_done, input int exp_dom,
                           input int inject_at, input int zero_at);
    int done_at = 0;
    int ndom = 0;
    int unstable = 0;
    pulse_err();
    for (int n = 1; n <= 60 && done_at == 0; n++) begin
      logic t0;
      if (n == zero_at) begin tec = '0; rec = '0; end
      strobe(tx_bit & ~dom[n]);
      t0 = tx_bit;
      if (!tx_bit) ndom++;
      if (rejoin_ok) done_at = n;
      if (n == inject_at) pulse_err();
      else repeat (2) @(negedge clk);
      if (tx_bit !== t0) unstable++;
    end
    check(done_at == exp_done, {tag, " done strobe"}, done_at, exp_done);
    check(ndom == exp_dom, {tag, " dominant bits driven"}, ndom, exp_dom);
    check(unstable == 0, "R10 tx changed between strobes", unstable, 0);
    check(busy == 1'b0, "R8 busy low at done", busy, 0);
    strobe(1'b1);
    check(rejoin_ok == 1'b0, "R8 done lasts one bit time", rejoin_ok, 0);
    check(busy == 1'b0 && tx_bit == 1'b1, "R9 no frame restarted", busy, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_bit == 1'b1, "R1 tx after reset", tx_bit, 1);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rejoin_ok == 1'b0, "R1 done after reset", rejoin_ok, 0);
    check(err_passive == 1'b0, "R1 passive after reset", err_passive, 0);
  endtask

  task automatic t_threshold();
    tec = 9'd127; rec = '0; @(negedge clk);
    check(err_passive == 1'b0, "R2 tec 127 active", err_passive, 0);
    tec = 9'd128; @(negedge clk);
    check(err_passive == 1'b1, "R2 tec 128 passive", err_passive, 1);
    tec = '0; rec = 9'd128; @(negedge clk);
    check(err_passive == 1'b1, "R2 rec 128 passive", err_passive, 1);
    rec = 9'd127; @(negedge clk);
    check(err_passive == 1'b0, "R2 rec 127 active", err_passive, 0);
    rec = '0; @(negedge clk);
  endtask

  task automatic t_active();
    tec = '0; rec = '0; @(negedge clk);
    run_frame("R4 R6 active quiet bus", 64'd0, 15, 6, 0, 0);
    run_frame("R4 bus ignored in flag", 64'h3C, 15, 6, 0, 0);
    run_frame("R6 delimiter restart", 64'h200, 17, 6, 0, 0);
    run_frame("R6 dominant after flag", 64'h100, 16, 6, 0, 0);
    run_frame("R9 pulse while busy", 64'd0, 15, 6, 4, 0);
  endtask

  task automatic t_passive();
    rec = 9'd200; @(negedge clk);
    run_frame("R5 R7 passive quiet bus", 64'd0, 21, 0, 0, 0);
    run_frame("R5 flag stretched", 64'hC, 23, 0, 0, 0);
    run_frame("R5 six dominant ends flag", 64'hFC, 21, 0, 0, 0);
    run_frame("R7 rejoin restart", 64'h40000, 24, 0, 0, 0);
    run_frame("R3 mode kept after counter drop", 64'd0, 21, 0, 0, 5);
    check(err_passive == 1'b0, "R2 passive cleared", err_passive, 0);
  endtask

  task automatic t_collide();
    int cnt = 0;
    tec = '0; rec = '0; @(negedge clk);
    pulse_err();
    for (int n = 1; n <= 14; n++) begin
      strobe(tx_bit);
      repeat (2) @(negedge clk);
    end
    @(negedge clk);
    rx_bit = 1'b1; bit_stb = 1'b1; err_det = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0; err_det = 1'b0;
    check(rejoin_ok == 1'b1, "R8 done at final strobe", rejoin_ok, 1);
    check(busy == 1'b0, "R9 pulse in completion clock ignored", busy, 0);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R9 still idle", busy, 0);
    @(negedge clk);
    rx_bit = 1'b1; bit_stb = 1'b1; err_det = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0; err_det = 1'b0;
    check(busy == 1'b1, "R9 pulse after completion accepted", busy, 1);
    check(tx_bit == 1'b1, "R4 flag waits for next strobe", tx_bit, 1);
    strobe(1'b1);
    check(tx_bit == 1'b0, "R4 flag starts at strobe 1", tx_bit, 0);
    cnt = 1;
    while (!rejoin_ok && cnt < 30) begin
      strobe(tx_bit);
      cnt++;
    end
    check(cnt == 15, "R4 collided frame length", cnt, 15);
    strobe(1'b1);
  endtask

  initial begin
    #1_000_000;
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_threshold();
    t_active();
    t_passive();
    t_collide();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule